// File: doc/BRIEF.md
# Eight-Region Page Attribute Lookup

This block works out the access attributes of one 4 KB page of a 32-bit address space. Software programs up to eight region descriptors. Each descriptor holds an enable, a base page and a power-of-two size. Packed words hold, for each region, a 4-bit data permission code, a 4-bit code permission code, and the data-cacheable, code-cacheable and write-buffer bits. For the page number on its input, the block returns two attribute bytes, one for user mode and one for privileged mode. Each byte carries read, write, execute, data-cacheable, write-back and code-cacheable bits.

Where enabled regions overlap, the region with the highest index decides the result. When the unit is switched off, every page gets full access, together with whichever cache attributes are globally enabled. The match and the decode are purely combinational. The two bytes are registered, so they appear one clock after the page and the configuration are presented. A permission code outside the defined set grants nothing of its kind. It also sets an error flag that stays set until reset.

Top module: `mpu_page_attr`

## Requirements
- R1: During and after a synchronous active-low reset, `user_attr`, `priv_attr` and `perm_err` are all 0 until the first lookup is registered, and reset is the only way to clear `perm_err`.
- R2: The outputs at a rising edge reflect the page and configuration present just before that edge, so a new page applied each cycle gives a new result each cycle, one cycle later.
- R3: Region n takes bits [32n+31:32n] of `region_cfg`: bit 0 enable, bits [5:1] size field f, bits [31:12] base page B. With f >= 11 it covers pages B up to B + 2^(f-11) - 1 inclusive, computed without wrap-around. With f < 11, or with enable clear, it covers no page. Region n uses nibble [4n+3:4n] of each permission word and bit n of each cache word.
- R4: When several enabled regions cover the page, only the highest-numbered one supplies the attributes.
- R5: With the unit enabled, a page covered by no enabled region returns 0 in both bytes.
- R6: Attribute bit positions are: 0x01 read, 0x02 write, 0x04 execute, 0x10 data-cacheable, 0x20 write-back, 0x40 code-cacheable; bits 3 and 7 are always 0. The data code decodes as: 0 none; 1 privileged read/write; 2 privileged read/write, user read; 3 read/write in both modes; 5 privileged read; 6 read in both modes.
- R7: The code permission code grants execute (0x04): codes 1 and 5 in privileged mode only, codes 2, 3 and 6 in both modes, code 0 in neither.
- R8: When `dcache_en` is 1 and the region's data-cacheable bit is set, both bytes get 0x10, plus 0x20 if its write-buffer bit is also set. When `icache_en` is 1 and its code-cacheable bit is set, both bytes get 0x40. Otherwise those bits are 0.
- R9: With `unit_en` 0, both bytes equal 0x07, plus 0x30 if `dcache_en` is 1, plus 0x40 if `icache_en` is 1, whatever the regions hold, and `perm_err` does not change.
- R10: A data code of 4 or 7..15, or a code code of 4 or 7..15, in the winning region grants no bit of its kind. It sets `perm_err` in the same cycle the attributes are registered, and `perm_err` then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_addr | input | 20 | Page number (address bits [31:12]) to look up |
| region_cfg | input | 256 | Eight packed region descriptors, region n in bits [32n+31:32n] |
| data_perm | input | 32 | Data permission codes, one nibble per region |
| code_perm | input | 32 | Code permission codes, one nibble per region |
| data_cacheable | input | 8 | Data-cacheable bit per region |
| code_cacheable | input | 8 | Code-cacheable bit per region |
| write_buffer | input | 8 | Write-buffer bit per region |
| unit_en | input | 1 | Protection unit enable |
| dcache_en | input | 1 | Global data cache enable |
| icache_en | input | 1 | Global code cache enable |
| user_attr | output | 8 | Registered user-mode attribute byte |
| priv_attr | output | 8 | Registered privileged-mode attribute byte |
| perm_err | output | 1 | Sticky undefined-permission-code flag |

## Verification
The block holds no state except the output registers and the error flag. A wrong match window, a wrong priority choice or a wrong decode therefore shows up in the attribute bytes on the very next clock after the page that exposes it. Errors in the size arithmetic only appear at the first and last page of a region and the page just past it, so the size sweep probes those edges for every size field. A flag that fails to latch, or that clears itself, shows up within one cycle of the offending lookup and then on every later lookup, until reset.

// File: rtl/mpu_pkg.sv
// Shared attribute encodings for the page attribute lookup.
// Assumes an 8-bit attribute byte with the bit layout given in the brief.
package mpu_pkg;

    typedef logic [7:0] attr_t;

    localparam attr_t ATTR_RD = 8'h01;
    localparam attr_t ATTR_WR = 8'h02;
    localparam attr_t ATTR_EX = 8'h04;
    localparam attr_t ATTR_DC = 8'h10;
    localparam attr_t ATTR_WB = 8'h20;
    localparam attr_t ATTR_CC = 8'h40;

    localparam attr_t ATTR_FULL = ATTR_RD | ATTR_WR | ATTR_EX;

    // Defined permission code values
    typedef enum logic [3:0] {
        PC_NONE   = 4'd0,
        PC_PRV    = 4'd1,
        PC_PRV_UR = 4'd2,
        PC_ALL    = 4'd3,
        PC_PRV_RO = 4'd5,
        PC_ALL_RO = 4'd6
    } perm_code_e;

endpackage

// File: rtl/mpu_region_match.sv
// Region window comparators, one per region.
// Each region covers pages [base, base + 2^(f+1-PAGE_SHIFT)) when
// f+1 >= PAGE_SHIFT and covers nothing otherwise or when disabled.
// Assumes CFG_W-bit descriptors: enable bit 0, size field from bit 1,
// base page in the top PAGE_W bits.
module mpu_region_match #(
    parameter int NUM_REGIONS = 8,
    parameter int CFG_W       = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int SIZE_W      = 5,
    parameter int PAGE_W      = CFG_W - PAGE_SHIFT
) (
    input  logic [PAGE_W-1:0]            page_addr,
    input  logic [NUM_REGIONS*CFG_W-1:0] region_cfg,
    output logic [NUM_REGIONS-1:0]       hit
);

    localparam int SPAN_W = PAGE_W + 1;

    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_rgn
            logic              en;
            logic [SIZE_W-1:0] fld;
            logic [PAGE_W-1:0] base;
            logic [SPAN_W-1:0] span;
            logic [SPAN_W-1:0] limit;

            assign en   = region_cfg[g*CFG_W];
            assign fld  = region_cfg[g*CFG_W+1 +: SIZE_W];
            assign base = region_cfg[g*CFG_W+PAGE_SHIFT +: PAGE_W];

            // Page count of the region; zero when smaller than one page
            always_comb begin
                span = '0;
                if ((int'(fld) + 1 >= PAGE_SHIFT) &&
                    (int'(fld) + 1 - PAGE_SHIFT < SPAN_W))
                    span = SPAN_W'(1) << (int'(fld) + 1 - PAGE_SHIFT);
            end

            assign limit = {1'b0, base} + span;

            assign hit[g] = en && (span != '0) && (page_addr >= base) &&
                            ({1'b0, page_addr} < limit);
        end
    endgenerate

endmodule

// File: rtl/mpu_prio_select.sv
// Priority pick among matching regions: the highest index wins.
// Assumes hit bits are already qualified by region enable.
module mpu_prio_select #(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [NUM_REGIONS-1:0] hit,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);

    // Scan upward so later (higher) hits overwrite earlier ones
    always_comb begin
        any_hit = |hit;
        win_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i])
                win_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mpu_perm_decode.sv
// Decodes one region's data and code permission codes into
// read/write/execute bits for user and privileged mode.
// Undefined codes grant nothing of their kind and raise code_bad.
module mpu_perm_decode
    import mpu_pkg::*;
#(
    parameter int PERM_W = 4
) (
    input  logic [PERM_W-1:0] data_code,
    input  logic [PERM_W-1:0] code_code,
    output logic [2:0]        user_rwx,
    output logic [2:0]        priv_rwx,
    output logic              code_bad
);

    logic [1:0] u_rw, p_rw;
    logic       u_x, p_x;
    logic       d_bad, c_bad;

    // Data code to read/write pair ({write, read})
    always_comb begin
        u_rw  = 2'b00;
        p_rw  = 2'b00;
        d_bad = 1'b0;
        case (data_code)
            PERM_W'(PC_NONE):   ;
            PERM_W'(PC_PRV):    p_rw = 2'b11;
            PERM_W'(PC_PRV_UR): begin p_rw = 2'b11; u_rw = 2'b01; end
            PERM_W'(PC_ALL):    begin p_rw = 2'b11; u_rw = 2'b11; end
            PERM_W'(PC_PRV_RO): p_rw = 2'b01;
            PERM_W'(PC_ALL_RO): begin p_rw = 2'b01; u_rw = 2'b01; end
            default:            d_bad = 1'b1;
        endcase
    end

    // Code code to execute bits
    always_comb begin
        u_x   = 1'b0;
        p_x   = 1'b0;
        c_bad = 1'b0;
        case (code_code)
            PERM_W'(PC_NONE):   ;
            PERM_W'(PC_PRV),
            PERM_W'(PC_PRV_RO): p_x = 1'b1;
            PERM_W'(PC_PRV_UR),
            PERM_W'(PC_ALL),
            PERM_W'(PC_ALL_RO): begin p_x = 1'b1; u_x = 1'b1; end
            default:            c_bad = 1'b1;
        endcase
    end

    assign user_rwx = {u_x, u_rw};
    assign priv_rwx = {p_x, p_rw};
    assign code_bad = d_bad | c_bad;

endmodule

// File: rtl/mpu_attr_build.sv
// Assembles the user and privileged attribute bytes from the decoded
// permissions, the winning region's cache bits and the global enables,
// and applies the disabled-unit override.
module mpu_attr_build
    import mpu_pkg::*;
(
    input  logic       unit_en,
    input  logic       dcache_en,
    input  logic       icache_en,
    input  logic       any_hit,
    input  logic [2:0] user_rwx,
    input  logic [2:0] priv_rwx,
    input  logic       code_bad,
    input  logic       rgn_dc,
    input  logic       rgn_cc,
    input  logic       rgn_wb,
    output attr_t      user_attr,
    output attr_t      priv_attr,
    output logic       bad_now
);

    attr_t cache_bits;
    attr_t off_bits;

    // Cache attributes of the winning region, gated by global enables
    always_comb begin
        cache_bits = '0;
        if (dcache_en && rgn_dc) begin
            cache_bits = cache_bits | ATTR_DC;
            if (rgn_wb)
                cache_bits = cache_bits | ATTR_WB;
        end
        if (icache_en && rgn_cc)
            cache_bits = cache_bits | ATTR_CC;
    end

    // Attributes returned while the unit is switched off
    always_comb begin
        off_bits = ATTR_FULL;
        if (dcache_en)
            off_bits = off_bits | ATTR_DC | ATTR_WB;
        if (icache_en)
            off_bits = off_bits | ATTR_CC;
    end

    // Final selection between off, no-match and matched cases
    always_comb begin
        if (!unit_en) begin
            user_attr = off_bits;
            priv_attr = off_bits;
            bad_now   = 1'b0;
        end else if (!any_hit) begin
            user_attr = '0;
            priv_attr = '0;
            bad_now   = 1'b0;
        end else begin
            user_attr = {5'b0, user_rwx} | cache_bits;
            priv_attr = {5'b0, priv_rwx} | cache_bits;
            bad_now   = code_bad;
        end
    end

endmodule

// File: rtl/mpu_page_attr.sv
// Page attribute lookup over NUM_REGIONS programmable regions.
// Combinational match, priority and decode; registered outputs one
// clock after the page is applied; sticky undefined-code flag.
// Assumes synchronous active-low reset and a stable configuration
// across the cycle in which a page is looked up.
module mpu_page_attr
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int CFG_W       = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int SIZE_W      = 5,
    parameter int PERM_W      = 4,
    parameter int PAGE_W      = CFG_W - PAGE_SHIFT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PAGE_W-1:0]             page_addr,
    input  logic [NUM_REGIONS*CFG_W-1:0]  region_cfg,
    input  logic [NUM_REGIONS*PERM_W-1:0] data_perm,
    input  logic [NUM_REGIONS*PERM_W-1:0] code_perm,
    input  logic [NUM_REGIONS-1:0]        data_cacheable,
    input  logic [NUM_REGIONS-1:0]        code_cacheable,
    input  logic [NUM_REGIONS-1:0]        write_buffer,
    input  logic                          unit_en,
    input  logic                          dcache_en,
    input  logic                          icache_en,
    output logic [7:0]                    user_attr,
    output logic [7:0]                    priv_attr,
    output logic                          perm_err
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic [NUM_REGIONS-1:0] hit;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic [PERM_W-1:0]      win_dcode, win_ccode;
    logic                   win_dc, win_cc, win_wb;
    logic [2:0]             user_rwx, priv_rwx;
    logic                   code_bad, bad_now;
    attr_t                  user_nxt, priv_nxt;

    mpu_region_match #(
        .NUM_REGIONS(NUM_REGIONS),
        .CFG_W      (CFG_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .SIZE_W     (SIZE_W),
        .PAGE_W     (PAGE_W)
    ) u_match (
        .page_addr (page_addr),
        .region_cfg(region_cfg),
        .hit       (hit)
    );

    mpu_prio_select #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) u_prio (
        .hit    (hit),
        .any_hit(any_hit),
        .win_idx(win_idx)
    );

    // Fields of the winning region
    always_comb begin
        win_dcode = data_perm[win_idx*PERM_W +: PERM_W];
        win_ccode = code_perm[win_idx*PERM_W +: PERM_W];
        win_dc    = data_cacheable[win_idx];
        win_cc    = code_cacheable[win_idx];
        win_wb    = write_buffer[win_idx];
    end

    mpu_perm_decode #(
        .PERM_W(PERM_W)
    ) u_dec (
        .data_code(win_dcode),
        .code_code(win_ccode),
        .user_rwx (user_rwx),
        .priv_rwx (priv_rwx),
        .code_bad (code_bad)
    );

    mpu_attr_build u_build (
        .unit_en  (unit_en),
        .dcache_en(dcache_en),
        .icache_en(icache_en),
        .any_hit  (any_hit),
        .user_rwx (user_rwx),
        .priv_rwx (priv_rwx),
        .code_bad (code_bad),
        .rgn_dc   (win_dc),
        .rgn_cc   (win_cc),
        .rgn_wb   (win_wb),
        .user_attr(user_nxt),
        .priv_attr(priv_nxt),
        .bad_now  (bad_now)
    );

    // Output register and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_attr <= '0;
            priv_attr <= '0;
            perm_err  <= 1'b0;
        end else begin
            user_attr <= user_nxt;
            priv_attr <= priv_nxt;
            perm_err  <= perm_err | bad_now;
        end
    end

endmodule

// File: rtl/mpu_attr_chk.sv
// Property checker for the page attribute lookup, bound to the top.
module mpu_attr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       unit_en,
    input logic       dcache_en,
    input logic       icache_en,
    input logic [7:0] user_attr,
    input logic [7:0] priv_attr,
    input logic       perm_err
);

    // R6
    user_within_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_attr[2:0] & ~priv_attr[2:0]) == 3'b000);

    // R6
    reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !user_attr[3] && !user_attr[7] && !priv_attr[3] && !priv_attr[7]);

    // R8
    wb_needs_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_attr[5] || user_attr[4]) && (!priv_attr[5] || priv_attr[4]));

    // R8
    cache_mode_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_attr[6:4] == priv_attr[6:4]);

    // R8
    dcache_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dcache_en |=> (user_attr[5:4] == 2'b00) && (priv_attr[5:4] == 2'b00));

    // R8
    icache_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !icache_en |=> !user_attr[6] && !priv_attr[6]);

    // R9
    unit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (user_attr == {1'b0, $past(icache_en), {2{$past(dcache_en)}}, 4'h7}) &&
                     (priv_attr == user_attr));

    // R9
    unit_off_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> $stable(perm_err));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_err |=> perm_err);

endmodule

bind mpu_page_attr mpu_attr_chk u_attr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_en  (unit_en),
    .dcache_en(dcache_en),
    .icache_en(icache_en),
    .user_attr(user_attr),
    .priv_attr(priv_attr),
    .perm_err (perm_err)
);

// File: tb/sim_mpu_page_attr.sv
`timescale 1ns/1ps
module sim_mpu_page_attr;

    localparam int N = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [19:0]   page;
    logic [31:0]   cfg [N];
    logic [N*32-1:0] cfg_flat;
    logic [31:0]   dperm, cperm;
    logic [7:0]    dcw, ccw, wbw;
    logic          uen, den, ien;
    logic [7:0]    user_o, priv_o;
    logic          err_o;

    int   total = 0;
    int   bad_cnt = 0;
    logic exp_err = 1'b0;
    logic done = 1'b0;

    always_comb begin
        for (int i = 0; i < N; i++)
            cfg_flat[i*32 +: 32] = cfg[i];
    end

    mpu_page_attr u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_addr     (page),
        .region_cfg    (cfg_flat),
        .data_perm     (dperm),
        .code_perm     (cperm),
        .data_cacheable(dcw),
        .code_cacheable(ccw),
        .write_buffer  (wbw),
        .unit_en       (uen),
        .dcache_en     (den),
        .icache_en     (ien),
        .user_attr     (user_o),
        .priv_attr     (priv_o),
        .perm_err      (err_o)
    );

    // Reference: {bad, user, priv} from the requirements
    function automatic logic [16:0] model(input logic [19:0] pg);
        logic [7:0] u, p;
        logic [3:0] d, c;
        logic       bd;
        int         win, f;
        longint     lo, pages;
        if (!uen) begin
            u = 8'h07;
            if (den) u = u | 8'h30;
            if (ien) u = u | 8'h40;
            return {1'b0, u, u};
        end
        win = -1;
        for (int n = 0; n < N; n++) begin
            f = int'(cfg[n][5:1]);
            if (cfg[n][0] && f >= 11) begin
                lo    = longint'(cfg[n][31:12]);
                pages = longint'(1) << (f - 11);
                if (longint'(pg) >= lo && longint'(pg) < lo + pages)
                    win = n;
            end
        end
        if (win < 0) return 17'h0;
        d = dperm[win*4 +: 4];
        c = cperm[win*4 +: 4];
        u = 8'h00; p = 8'h00; bd = 1'b0;
        case (d)
            4'd0: ;
            4'd1: p = 8'h03;
            4'd2: begin p = 8'h03; u = 8'h01; end
            4'd3: begin p = 8'h03; u = 8'h03; end
            4'd5: p = 8'h01;
            4'd6: begin p = 8'h01; u = 8'h01; end
            default: bd = 1'b1;
        endcase
        case (c)
            4'd0: ;
            4'd1, 4'd5: p = p | 8'h04;
            4'd2, 4'd3, 4'd6: begin p = p | 8'h04; u = u | 8'h04; end
            default: bd = 1'b1;
        endcase
        if (den && dcw[win]) begin
            u = u | 8'h10; p = p | 8'h10;
            if (wbw[win]) begin u = u | 8'h20; p = p | 8'h20; end
        end
        if (ien && ccw[win]) begin u = u | 8'h40; p = p | 8'h40; end
        return {bd, u, p};
    endfunction

    task automatic compare(input string tag, input logic [19:0] pg, input logic [16:0] e);
        exp_err = exp_err | e[16];
        total++;
        if (user_o !== e[15:8] || priv_o !== e[7:0] || err_o !== exp_err) begin
            bad_cnt++;
            $display("FAIL %s page=%05h user=%02h exp=%02h priv=%02h exp=%02h err=%0b exp=%0b",
                     tag, pg, user_o, e[15:8], priv_o, e[7:0], err_o, exp_err);
        end
    endtask

    // Apply one page, sample after the registering edge
    task automatic probe(input string tag, input logic [19:0] pg);
        logic [16:0] e;
        @(negedge clk);
        page = pg;
        e = model(pg);
        @(negedge clk);
        compare(tag, pg, e);
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < N; i++) cfg[i] = 32'h0;
        dperm = 32'h0; cperm = 32'h0;
        dcw = 8'h0; ccw = 8'h0; wbw = 8'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_err = 1'b0;
        total++;
        if (user_o !== 8'h00 || priv_o !== 8'h00 || err_o !== 1'b0) begin
            bad_cnt++;
            $display("FAIL R1 reset user=%02h priv=%02h err=%0b exp=00/00/0",
                     user_o, priv_o, err_o);
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad_cnt);
            $finish;
        end
    end

    initial begin
        logic [16:0] prev_e;
        logic [19:0] prev_pg;
        rst_n = 1'b0; page = 20'h0;
        uen = 1'b0; den = 1'b0; ien = 1'b0;
        clear_cfg();
        do_reset();

        // R9: unit off, regions loaded with bad codes must not matter
        cfg[0] = 32'h0000_003F; dperm = 32'hFFFF_FFFF; cperm = 32'h7777_7777;
        for (int k = 0; k < 4; k++) begin
            den = k[0]; ien = k[1];
            probe("R9", 20'h00000);
            probe("R9", 20'hFFFFF);
        end

        // R6 R7 R10: all permission code pairs on a whole-space region 0
        clear_cfg();
        uen = 1'b1; den = 1'b1; ien = 1'b1;
        cfg[0] = 32'h0000_003F;
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 16; c++) begin
                dperm = {28'h0, 4'(d)};
                cperm = {28'h0, 4'(c)};
                dcw = {7'h0, 1'(d)}; wbw = {7'h0, 1'(c)}; ccw = {7'h0, 1'(d >> 1)};
                probe("R6_R7_R10", 20'((d * 16 + c) * 4099));
            end
        end
        // R10: flag stays after good codes, cleared by reset (R1)
        dperm = 32'h3; cperm = 32'h3;
        probe("R10", 20'h12345);
        do_reset();

        // R8: cache attribute combinations
        cfg[0] = 32'h0000_003F; dperm = 32'h3; cperm = 32'h2;
        for (int k = 0; k < 32; k++) begin
            den = k[0]; ien = k[1];
            dcw = {7'h0, k[2]}; wbw = {7'h0, k[3]}; ccw = {7'h0, k[4]};
            probe("R8", 20'h0ABCD);
        end
        den = 1'b1; ien = 1'b1;

        // R3: size field sweep on region 2 with base page 0x40000
        clear_cfg();
        dperm = 32'h0000_0300; cperm = 32'h0000_0600;
        for (int f = 0; f < 32; f++) begin
            longint pages, last;
            cfg[2] = {20'h40000, 6'h0, 5'(f), 1'b1};
            pages = (f >= 11) ? (longint'(1) << (f - 11)) : 0;
            last  = 64'h40000 + pages;
            probe("R3", 20'h3FFFF);
            probe("R3", 20'h40000);
            if (pages > 1) probe("R3", 20'(last - 1));
            if (last <= 64'hFFFFF) probe("R3", 20'(last));
        end
        // R3: disabled region covers nothing
        cfg[2] = {20'h40000, 6'h0, 5'd20, 1'b0};
        probe("R3", 20'h40000);

        // R4: stacked whole-space regions, drop the top one each step
        clear_cfg();
        dperm = 32'h3216_5321; cperm = 32'h1065_3210;
        dcw = 8'hA5; wbw = 8'h3C; ccw = 8'h96;
        for (int k = N - 1; k >= 0; k--) begin
            for (int i = 0; i < N; i++)
                cfg[i] = (i <= k) ? 32'h0000_003F : 32'h0000_003E;
            probe("R4", 20'(k * 20'h1111));
        end
        // R4: small high region inside large low region
        clear_cfg();
        dperm = 32'h0500_0300; cperm = 32'h0100_0200;
        cfg[2] = 32'h0000_003F;
        cfg[6] = {20'h00100, 6'h0, 5'd18, 1'b1};
        probe("R4", 20'h000FF);
        probe("R4", 20'h00100);
        probe("R4", 20'h001FF);
        probe("R4", 20'h00200);

        // R5: only a small region, pages outside it
        cfg[2] = 32'h0;
        probe("R5", 20'h00000);
        probe("R5", 20'h00300);
        probe("R5", 20'hFFFFF);

        // R2: one new page per cycle, result one cycle later
        cfg[2] = 32'h0000_003F;
        @(negedge clk);
        prev_pg = 20'h00150; page = prev_pg; prev_e = model(prev_pg);
        for (int k = 0; k < 6; k++) begin
            logic [19:0] npg;
            @(negedge clk);
            compare("R2", prev_pg, prev_e);
            npg = (k[0]) ? 20'h00180 + 20'(k) : 20'h00500 + 20'(k);
            page = npg; prev_pg = npg; prev_e = model(npg);
        end
        @(negedge clk);
        compare("R2", prev_pg, prev_e);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad_cnt);
        $finish;
    end

endmodule